// File: doc/BRIEF.md
# Look-Ahead First-Order Recursive Filter

This block is a first-order recursive low-pass filter of the kind that smooths the phase error in a tracking loop. Its behaviour matches the one-step recursion y[n+1] = a·y[n] + b·x[n]. The recursion is unrolled by one step, so each new output is built from the output two samples back, the pole coefficient squared, and a two-tap pre-filter on the current and previous inputs. Because of this, the feedback path holds two registers. The feedback multiply and the feedback add each get a full clock cycle, and the filter still accepts one sample on every clock.

The integrator supplies three constant coefficients: b, the product a·b and the square a². All three are signed Q1.17 codes, where value = code / 2^17. Samples are 16-bit signed integers. Each sample is accepted by raising `in_valid`. The filtered sample appears a fixed number of cycles later together with `out_valid`. Internally the recursion state carries extra fraction bits and headroom bits. The only rounding to the output grid happens at the output, and that output is clipped symmetrically.

Top module: `lookahead_iir`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `out_valid` and `out_data` become 0. The two recursion registers and the pre-filter sample history are also cleared, so the first output after reset equals b·x0 rounded.
- R2: `out_valid` is high in exactly those cycles that follow, by three clock edges, an edge at which `in_valid` was sampled high. One sample can be accepted on every clock.
- R3: With `coef_asq` = a² and `coef_ab` = a·b (both rounded to Q1.17), the output for the k-th accepted sample lies within 1 LSB of round(y[k+1]), where y[n+1] = a·y[n] + b·x[n] and y[0] = 0.
- R4: A cycle with `in_valid` low advances neither the recursion nor the sample history. Idle cycles placed between samples leave the output sequence unchanged.
- R5: `out_data` is clipped to the range -32767 to +32767. The code -32768 never appears.
- R6: In every cycle in which `out_valid` is low, `out_data` keeps the value it had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample |
| coef_b | input | 18 | Input gain b, signed Q1.17 |
| coef_ab | input | 18 | Product a·b, signed Q1.17 |
| coef_asq | input | 18 | Feedback coefficient a², signed Q1.17 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Filtered, clipped output sample |

## Verification
Four properties are checked on every cycle:
- the three-cycle relation between `in_valid` and `out_valid`;
- the clear state that reset leaves behind;
- the hold of `out_data` while no result is flagged;
- the absence of the code -32768.

Numerical agreement with the one-step recursion can only be shown by the bench's scenarios, which compare against a real-valued model. The same holds for the claim that idle gaps change nothing, for the memory-free first output after a mid-stream reset, and for clipping under a gain above one.

// File: rtl/la_iir_pkg.sv
package la_iir_pkg;

  localparam int unsigned FIR_TAPS = 2;

  // Arithmetic shift right with round-half-up.
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v,
                                                 input int unsigned sh);
    logic signed [63:0] half;
    if (sh == 0) return v;
    half = 64'sd1 <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Limit a value to the closed range [lo, hi].
  function automatic logic signed [63:0] clamp(input logic signed [63:0] v,
                                               input logic signed [63:0] lo,
                                               input logic signed [63:0] hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/la_iir_fir.sv
module la_iir_fir
  import la_iir_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int CF = 17,
  parameter int GW = 8,
  parameter int SW = DW + GW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_ab,
  output logic                 f_valid,
  output logic signed [SW-1:0] f_sum
);
  localparam int PW = DW + CW;
  localparam int TW = DW + GW + 1;

  logic signed [DW-1:0] x_last;
  logic                 v1;
  logic signed [CW-1:0] tap_c [FIR_TAPS];
  logic signed [DW-1:0] tap_x [FIR_TAPS];
  logic signed [TW-1:0] tap_t [FIR_TAPS];
  logic signed [SW-1:0] t_sum;

  // tap 0: b on the newest sample, tap 1: a*b on the previous one
  assign tap_c[0] = coef_b;
  assign tap_x[0] = in_data;
  assign tap_c[1] = coef_ab;
  assign tap_x[1] = x_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_last <= '0;
      v1     <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) x_last <= in_data;
    end
  end

  for (genvar t = 0; t < FIR_TAPS; t++) begin : g_tap
    logic signed [PW-1:0] prod;
    always_ff @(posedge clk) begin
      if (rst) prod <= '0;
      else     prod <= PW'(64'(tap_c[t]) * 64'(tap_x[t]));
    end
    assign tap_t[t] = TW'(rnd_shr(64'(prod), CF - GW));
  end

  always_comb begin
    t_sum = '0;
    for (int t = 0; t < FIR_TAPS; t++) t_sum = t_sum + SW'(tap_t[t]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid <= 1'b0;
      f_sum   <= '0;
    end else begin
      f_valid <= v1;
      if (v1) f_sum <= t_sum;
    end
  end
endmodule

// File: rtl/la_iir_loop.sv
module la_iir_loop
  import la_iir_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int CF = 17,
  parameter int GW = 8,
  parameter int HW = 3,
  parameter int SW = DW + GW + 2,
  parameter int IW = DW + GW + HW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [SW-1:0] f_sum,
  input  logic signed [CW-1:0] coef_asq,
  output logic signed [IW-1:0] y_state,
  output logic                 y_valid
);
  localparam logic signed [63:0] YMAX = (64'sd1 <<< (IW - 1)) - 64'sd1;
  localparam logic signed [63:0] YMIN = -YMAX - 64'sd1;

  logic signed [IW-1:0] y_q, p_q, y_d, p_d;

  // loop: y_q -> multiply -> p_q -> add -> y_q (two registers)
  assign y_d = IW'(clamp(64'(p_q) + 64'(f_sum), YMIN, YMAX));
  assign p_d = IW'(clamp(rnd_shr(64'(coef_asq) * 64'(y_q), CF), YMIN, YMAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q     <= '0;
      p_q     <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= step;
      if (step) begin
        y_q <= y_d;
        p_q <= p_d;
      end
    end
  end

  assign y_state = y_q;
endmodule

// File: rtl/la_iir_out.sv
module la_iir_out
  import la_iir_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 8,
  parameter int IW = DW + GW + 3
) (
  input  logic signed [IW-1:0] y_state,
  output logic signed [DW-1:0] out_data
);
  localparam logic signed [63:0] DMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;

  assign out_data = DW'(clamp(rnd_shr(64'(y_state), GW), -DMAX, DMAX));
endmodule

// File: rtl/lookahead_iir.sv
module lookahead_iir #(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int CF = 17,
  parameter int GW = 8,
  parameter int HW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_ab,
  input  logic signed [CW-1:0] coef_asq,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int SW = DW + GW + 2;
  localparam int IW = DW + GW + HW;

  logic                 fir_valid;
  logic signed [SW-1:0] fir_sum;
  logic signed [IW-1:0] loop_y;

  la_iir_fir #(.DW(DW), .CW(CW), .CF(CF), .GW(GW), .SW(SW)) u_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_b(coef_b), .coef_ab(coef_ab),
    .f_valid(fir_valid), .f_sum(fir_sum)
  );

  la_iir_loop #(.DW(DW), .CW(CW), .CF(CF), .GW(GW), .HW(HW), .SW(SW), .IW(IW)) u_loop (
    .clk(clk), .rst(rst), .step(fir_valid), .f_sum(fir_sum),
    .coef_asq(coef_asq), .y_state(loop_y), .y_valid(out_valid)
  );

  la_iir_out #(.DW(DW), .GW(GW), .IW(IW)) u_out (
    .y_state(loop_y), .out_data(out_data)
  );
endmodule

// File: rtl/la_iir_chk.sv
module la_iir_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);
  localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= 2'(cyc + 2'd1);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r5_no_min_code: assert property (@(posedge clk) disable iff (rst)
    out_data != DMIN);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && !out_valid) |-> $stable(out_data));
endmodule

bind lookahead_iir la_iir_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_lookahead_iir.sv
module sim_lookahead_iir;
  localparam int DW = 16;
  localparam int CW = 18;
  localparam int NX = 16;
  localparam int NSET = 4;
  // input samples
  localparam int XTAB [NX] = '{32767, 32767, 32767, 32767, -32768, -32768, 0, 1000,
                               -1000, 12345, -23456, 5, -5, 30000, -30000, 0};
  // {a code, b code, idle cycles after each sample}
  localparam int CTAB [NSET][3] = '{'{98304, 32768, 0}, '{65536, 65536, 1},
                                    '{-65536, 65536, 2}, '{122880, 8192, 3}};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic signed [CW-1:0] coef_b = '0, coef_ab = '0, coef_asq = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  always #10 clk = ~clk;

  lookahead_iir u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_b(coef_b), .coef_ab(coef_ab), .coef_asq(coef_asq),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_req = "R3";
  real ar = 0.0, br = 0.0, ym = 0.0;
  int expq [$];
  logic [2:0] hist;
  int prev_out = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip_round(input real v);
    real r;
    r = $floor(v + 0.5);
    if (r > 32767.0) return 32767;
    if (r < -32767.0) return -32767;
    return $rtoi(r);
  endfunction

  always @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[1:0], in_valid};
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid == hist[2], "R2", int'(out_valid), int'(hist[2]));
      if (out_valid) begin
        if (expq.size() == 0) chk(1'b0, cur_req, int'(out_data), 99999);
        else begin
          int e;
          e = expq.pop_front();
          chk((int'(out_data) - e) <= 1 && (e - int'(out_data)) <= 1,
              cur_req, int'(out_data), e);
        end
      end else begin
        chk(int'(out_data) == prev_out, "R6", int'(out_data), prev_out);
      end
      prev_out = int'(out_data);
    end
  end

  task automatic set_coefs(input int a, input int b);
    longint la, lb;
    la = a;
    lb = b;
    coef_b   = CW'(b);
    coef_asq = CW'((la * la + 64'sd65536) >>> 17);
    coef_ab  = CW'((la * lb + 64'sd65536) >>> 17);
    ar = real'(a) / 131072.0;
    br = real'(b) / 131072.0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    expq.delete();
    ym = 0.0;
    repeat (2) @(negedge clk);
    chk(!out_valid && out_data == '0, "R1", int'(out_data), 0);
    prev_out = 0;
    rst = 1'b0;
  endtask

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = DW'(x);
    ym = ar * ym + br * real'(x);
    expq.push_back(clip_round(ym));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    set_coefs(98304, 32768);
    do_reset();
    // table walk: R3 without gaps, R4 with idle cycles between samples
    for (int s = 0; s < NSET; s++) begin
      set_coefs(CTAB[s][0], CTAB[s][1]);
      do_reset();
      if (CTAB[s][2] == 0) cur_req = "R3";
      else                 cur_req = "R4";
      for (int i = 0; i < NX; i++) begin
        send(XTAB[i]);
        if (CTAB[s][2] > 0) idle(CTAB[s][2]);
      end
      idle(6);
    end
    // R3: long step response with a slow pole
    set_coefs(122880, 8192);
    do_reset();
    cur_req = "R3";
    for (int i = 0; i < 40; i++) send(20000);
    for (int i = 0; i < 20; i++) send(-7000);
    idle(6);
    // R1: reset in mid-stream wipes the memory of earlier samples
    set_coefs(98304, 32768);
    do_reset();
    for (int i = 0; i < 5; i++) send(30000);
    do_reset();
    cur_req = "R1";
    send(-12000);
    idle(6);
    // R5: gain near 4 drives the output into symmetric clipping
    set_coefs(98304, 131071);
    do_reset();
    cur_req = "R5";
    for (int i = 0; i < 24; i++) send(32767);
    idle(5);
    chk(out_data == 16'sd32767, "R5", int'(out_data), 32767);
    for (int i = 0; i < 24; i++) send(-32768);
    idle(5);
    chk(out_data == -16'sd32767, "R5", int'(out_data), -32767);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule